// File: doc/BRIEF.md
# Inter-Processor Command Dispatcher

The dispatcher accepts one command word per write strobe and turns it into a single action against one CPU of a multi-CPU cluster. Four actions exist. It can post an interrupt vector to the CPU, pulse the CPU's reset line and then let it run, stop the CPU, or let a stopped CPU run again. The target CPU and the action are carried together in the same word, so one store from software is enough to steer any CPU.

The number of CPUs that are actually populated comes in on an input. Commands aimed at an absent CPU vanish without a trace. A reset command is honoured only when its vector field holds the power-on-reset code. Any other vector drops the command and raises a sticky error flag that only the block reset clears. Each CPU has a run flag that the outputs show directly. The reset pulse length is a parameter.

Top module: `ipi_cmd_dispatch`

## Requirements
- R1: After reset, no interrupt is posted, every cpu_reset bit is low, cmd_err is low, and cpu_run equals the BOOT_RUN parameter (default: only CPU 0 running).
- R2: A type 0 command to a present CPU raises exactly that CPU's bit of intr_post for one cycle, starting the cycle after the write. intr_vec holds the command's vector from that cycle onward.
- R3: A type 2 command clears the target's cpu_run bit, and a type 3 command sets it, in the cycle after the write.
- R4: A type 1 command whose vector equals POR_VEC drives the target's cpu_reset high for exactly RST_CYCLES cycles, starting the cycle after the write. cpu_run is low during the pulse and goes high in the cycle the pulse ends.
- R5: While a CPU's reset pulse is active, type 3 and type 2 commands to it have no effect: cpu_run stays low and still rises when the pulse ends. A new valid reset command restarts the full pulse.
- R6: A command whose target number is not below present_cpus, or not below NUM_CPUS, changes no output: no post, no reset, no run change, and no error.
- R7: A type 1 command to a present CPU with a vector other than POR_VEC changes neither cpu_reset nor cpu_run. It sets cmd_err in the next cycle, and cmd_err then stays high until the block is reset.
- R8: The command word fields are type in bits 17:16 (0 interrupt, 1 reset, 2 halt, 3 resume), target CPU in bits 12:8 and vector in bits 5:0. All other bits are ignored.
- R9: With cmd_wr low, cmd_word has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Write strobe for cmd_word |
| cmd_word | input | 32 | Command word |
| present_cpus | input | 6 | Number of populated CPUs |
| intr_post | output | NUM_CPUS | One-cycle interrupt post, one bit per CPU |
| intr_vec | output | 6 | Vector of the most recent post |
| cpu_reset | output | NUM_CPUS | Per-CPU reset pulse |
| cpu_run | output | NUM_CPUS | Per-CPU run enable |
| cmd_err | output | 1 | Sticky flag for a rejected reset command |

## Verification
The hardest case to reach from the ports is a command that lands inside a reset pulse that is already running. The resume, halt or second reset must arrive a known number of cycles into the pulse for the check to mean anything. The bench drives every write on the falling edge and counts edges from the reset command. This places a resume one cycle into the pulse and a halt two cycles in, and restarts a reset two cycles into its own pulse. It then checks cpu_reset and cpu_run on the exact cycle where a faulty counter or run flag would differ.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [1:0] {
    CMD_INTR   = 2'd0,
    CMD_RESET  = 2'd1,
    CMD_HALT   = 2'd2,
    CMD_RESUME = 2'd3
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e   kind;
    logic [4:0]  tgt;
    logic [5:0]  vec;
  } cmd_t;

  // Field positions: kind 17:16, target 12:8, vector 5:0
  function automatic cmd_t unpack_cmd(input logic [31:0] w);
    cmd_t c;
    c.kind = cmd_kind_e'(w[17:16]);
    c.tgt  = w[12:8];
    c.vec  = w[5:0];
    return c;
  endfunction

  function automatic logic tgt_ok(input logic [4:0] tgt, input logic [5:0] present,
                                  input int ncpu);
    return (int'(tgt) < int'(present)) && (int'(tgt) < ncpu);
  endfunction

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_pkg::*;
#(
  parameter int          NUM_CPUS = 8,
  parameter logic [5:0]  POR_VEC  = 6'h01
) (
  input  logic                cmd_wr,
  input  logic [31:0]         cmd_word,
  input  logic [5:0]          present_cpus,
  output logic [5:0]          dec_vec,
  output logic [NUM_CPUS-1:0] post_sel,
  output logic [NUM_CPUS-1:0] rst_sel,
  output logic [NUM_CPUS-1:0] halt_sel,
  output logic [NUM_CPUS-1:0] resume_sel,
  output logic                ev_post,
  output logic                ev_bad_rst,
  output logic                ev_drop
);

  cmd_t                c;
  logic                in_range;
  logic                ev_rst, ev_halt, ev_resume;
  logic [NUM_CPUS-1:0] tgt_hot;
  logic                unused_bits;

  assign c           = unpack_cmd(cmd_word);
  assign in_range    = tgt_ok(c.tgt, present_cpus, NUM_CPUS);
  assign dec_vec     = c.vec;
  assign unused_bits = ^{cmd_word[31:18], cmd_word[15:13], cmd_word[7:6]};

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_hot
    assign tgt_hot[i] = (int'(c.tgt) == i);
  end

  always_comb begin
    ev_post    = cmd_wr && in_range && (c.kind == CMD_INTR);
    ev_rst     = cmd_wr && in_range && (c.kind == CMD_RESET) && (c.vec == POR_VEC);
    ev_bad_rst = cmd_wr && in_range && (c.kind == CMD_RESET) && (c.vec != POR_VEC);
    ev_halt    = cmd_wr && in_range && (c.kind == CMD_HALT);
    ev_resume  = cmd_wr && in_range && (c.kind == CMD_RESUME);
    ev_drop    = cmd_wr && !in_range;
    post_sel   = ev_post   ? tgt_hot : '0;
    rst_sel    = ev_rst    ? tgt_hot : '0;
    halt_sel   = ev_halt   ? tgt_hot : '0;
    resume_sel = ev_resume ? tgt_hot : '0;
  end

endmodule

// File: rtl/ipi_intr_post.sv
module ipi_intr_post #(
  parameter int NUM_CPUS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_post,
  input  logic [NUM_CPUS-1:0] post_sel,
  input  logic [5:0]          dec_vec,
  output logic [NUM_CPUS-1:0] intr_post,
  output logic [5:0]          intr_vec
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intr_post <= '0;
      intr_vec  <= '0;
    end else begin
      intr_post <= post_sel;
      if (ev_post) intr_vec <= dec_vec;
    end
  end

  AST_POST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(intr_post)); // R2
  AST_POST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_post |=> ((intr_post != '0) && (intr_vec == $past(dec_vec)))); // R2
  AST_POST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_post |=> (intr_post == '0)); // R9

endmodule

// File: rtl/ipi_cpu_ctrl.sv
module ipi_cpu_ctrl #(
  parameter int   RST_CYCLES = 4,
  parameter logic BOOT_RUN   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_go,
  input  logic halt_go,
  input  logic resume_go,
  output logic cpu_reset,
  output logic cpu_run
);

  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      run_q <= BOOT_RUN;
    end else if (rst_go) begin
      cnt   <= CW'(RST_CYCLES);
      run_q <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) run_q <= 1'b1;
    end else if (halt_go) begin
      run_q <= 1'b0;
    end else if (resume_go) begin
      run_q <= 1'b1;
    end
  end

  assign cpu_reset = (cnt != '0);
  assign cpu_run   = run_q;

  AST_RESET_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_go |=> cpu_reset); // R4
  AST_RUN_AT_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_reset) |-> cpu_run); // R4
  AST_NO_RUN_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset |-> !cpu_run); // R5

endmodule

// File: rtl/ipi_cmd_dispatch.sv
module ipi_cmd_dispatch
  import ipi_pkg::*;
#(
  parameter int                  NUM_CPUS   = 8,
  parameter int                  RST_CYCLES = 4,
  parameter logic [5:0]          POR_VEC    = 6'h01,
  parameter logic [NUM_CPUS-1:0] BOOT_RUN   = NUM_CPUS'(1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wr,
  input  logic [31:0]         cmd_word,
  input  logic [5:0]          present_cpus,
  output logic [NUM_CPUS-1:0] intr_post,
  output logic [5:0]          intr_vec,
  output logic [NUM_CPUS-1:0] cpu_reset,
  output logic [NUM_CPUS-1:0] cpu_run,
  output logic                cmd_err
);

  logic [5:0]          dec_vec;
  logic [NUM_CPUS-1:0] post_sel, rst_sel, halt_sel, resume_sel;
  logic                ev_post, ev_bad_rst, ev_drop;

  ipi_cmd_decode #(.NUM_CPUS(NUM_CPUS), .POR_VEC(POR_VEC)) u_dec (
    .cmd_wr      (cmd_wr),
    .cmd_word    (cmd_word),
    .present_cpus(present_cpus),
    .dec_vec     (dec_vec),
    .post_sel    (post_sel),
    .rst_sel     (rst_sel),
    .halt_sel    (halt_sel),
    .resume_sel  (resume_sel),
    .ev_post     (ev_post),
    .ev_bad_rst  (ev_bad_rst),
    .ev_drop     (ev_drop)
  );

  ipi_intr_post #(.NUM_CPUS(NUM_CPUS)) u_post (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_post  (ev_post),
    .post_sel (post_sel),
    .dec_vec  (dec_vec),
    .intr_post(intr_post),
    .intr_vec (intr_vec)
  );

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_cpu
    ipi_cpu_ctrl #(.RST_CYCLES(RST_CYCLES), .BOOT_RUN(BOOT_RUN[i])) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .rst_go   (rst_sel[i]),
      .halt_go  (halt_sel[i]),
      .resume_go(resume_sel[i]),
      .cpu_reset(cpu_reset[i]),
      .cpu_run  (cpu_run[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          cmd_err <= 1'b0;
    else if (ev_bad_rst) cmd_err <= 1'b1;
  end

  AST_BAD_RESET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_rst |=> cmd_err); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err); // R7
  AST_DROP_NO_POST: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> (intr_post == '0)); // R6
  AST_DROP_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drop && !cmd_err) |=> !cmd_err); // R6

endmodule

// File: tb/test_ipi_cmd_dispatch.sv
module test_ipi_cmd_dispatch;

  localparam int NCPU = 8;
  localparam int RSTC = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_wr = 1'b0;
  logic [31:0]     cmd_word = '0;
  logic [5:0]      present_cpus = 6'd8;
  logic [NCPU-1:0] intr_post, cpu_reset, cpu_run;
  logic [5:0]      intr_vec;
  logic            cmd_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ipi_cmd_dispatch i_ipi_cmd_dispatch (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .present_cpus(present_cpus), .intr_post(intr_post), .intr_vec(intr_vec),
    .cpu_reset(cpu_reset), .cpu_run(cpu_run), .cmd_err(cmd_err)
  );

  function automatic logic [31:0] mk(input logic [1:0] k, input logic [4:0] t,
                                     input logic [5:0] v, input bit junk);
    return {junk ? 14'h3FFF : 14'h0, k, junk ? 3'h7 : 3'h0, t,
            junk ? 2'h3 : 2'h0, v};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the acting edge.
  task automatic send(input logic [1:0] k, input logic [4:0] t, input logic [5:0] v,
                      input bit junk = 1'b0);
    cmd_wr   = 1'b1;
    cmd_word = mk(k, t, v, junk);
    @(negedge clk);
    cmd_wr   = 1'b0;
    cmd_word = '0;
  endtask

  task automatic t_reset_state;
    chk("R1 intr_post", intr_post, 0);
    chk("R1 cpu_reset", cpu_reset, 0);
    chk("R1 cpu_run", cpu_run, 8'h01);
    chk("R1 cmd_err", cmd_err, 0);
  endtask

  task automatic t_interrupt;
    send(2'd0, 5'd3, 6'h2A);
    chk("R2 post cpu3", intr_post, 8'h08);
    chk("R2 vec 2A", intr_vec, 6'h2A);
    @(negedge clk);
    chk("R2 post one cycle", intr_post, 0);
    chk("R2 vec held", intr_vec, 6'h2A);
    send(2'd0, 5'd0, 6'h3F);
    chk("R2 post cpu0", intr_post, 8'h01);
    chk("R2 vec 3F", intr_vec, 6'h3F);
    @(negedge clk);
  endtask

  task automatic t_halt_resume;
    send(2'd2, 5'd0, 6'h0);
    chk("R3 halt cpu0", cpu_run, 8'h00);
    send(2'd3, 5'd0, 6'h0);
    chk("R3 resume cpu0", cpu_run, 8'h01);
    send(2'd3, 5'd5, 6'h0);
    chk("R3 resume cpu5", cpu_run, 8'h21);
  endtask

  task automatic t_reset_pulse;
    send(2'd1, 5'd2, 6'h01);
    for (int k = 1; k <= RSTC; k++) begin
      chk("R4 reset high", cpu_reset, 8'h04);
      chk("R4 run low in pulse", cpu_run[2], 0);
      @(negedge clk);
    end
    chk("R4 reset ended", cpu_reset, 0);
    chk("R4 run after pulse", cpu_run[2], 1);
    chk("R4 no error", cmd_err, 0);
  endtask

  task automatic t_in_pulse;
    send(2'd1, 5'd1, 6'h01);
    send(2'd3, 5'd1, 6'h0);
    chk("R5 resume ignored", cpu_run[1], 0);
    send(2'd2, 5'd1, 6'h0);
    chk("R5 still resetting", cpu_reset[1], 1);
    @(negedge clk);
    @(negedge clk);
    chk("R5 pulse done", cpu_reset[1], 0);
    chk("R5 run despite halt", cpu_run[1], 1);
    send(2'd1, 5'd1, 6'h01);
    @(negedge clk);
    @(negedge clk);
    send(2'd1, 5'd1, 6'h01);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk("R5 restarted pulse", cpu_reset[1], 1);
    @(negedge clk);
    chk("R5 restart end", cpu_reset[1], 0);
    chk("R5 run after restart", cpu_run[1], 1);
  endtask

  task automatic t_drop;
    logic [NCPU-1:0] run_before;
    present_cpus = 6'd4;
    run_before = cpu_run;
    send(2'd2, 5'd5, 6'h0);
    chk("R6 halt absent cpu", cpu_run, run_before);
    send(2'd0, 5'd5, 6'h11);
    chk("R6 no post absent", intr_post, 0);
    send(2'd0, 5'd31, 6'h11);
    chk("R6 no post cpu31", intr_post, 0);
    send(2'd1, 5'd6, 6'h01);
    chk("R6 no reset absent", cpu_reset, 0);
    send(2'd1, 5'd7, 6'h09);
    chk("R6 no error absent", cmd_err, 0);
    present_cpus = 6'd8;
  endtask

  task automatic t_bad_reset;
    logic [NCPU-1:0] run_before;
    run_before = cpu_run;
    send(2'd1, 5'd0, 6'h05);
    chk("R7 no reset", cpu_reset, 0);
    chk("R7 run kept", cpu_run, run_before);
    chk("R7 error set", cmd_err, 1);
    send(2'd0, 5'd2, 6'h01);
    send(2'd3, 5'd0, 6'h00);
    repeat (3) @(negedge clk);
    chk("R7 error sticky", cmd_err, 1);
  endtask

  task automatic t_fields;
    send(2'd0, 5'd6, 6'h15, 1'b1);
    chk("R8 junk post cpu6", intr_post, 8'h40);
    chk("R8 junk vec", intr_vec, 6'h15);
    send(2'd2, 5'd6, 6'h00, 1'b1);
    chk("R8 junk halt cpu6", cpu_run[6], 0);
  endtask

  task automatic t_no_strobe;
    logic [NCPU-1:0] run_before;
    run_before = cpu_run;
    cmd_word = mk(2'd0, 5'd4, 6'h2B, 1'b0);
    @(negedge clk);
    chk("R9 no post", intr_post, 0);
    cmd_word = mk(2'd2, 5'd0, 6'h00, 1'b0);
    @(negedge clk);
    chk("R9 run unchanged", cpu_run, run_before);
    cmd_word = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_interrupt();
    t_halt_resume();
    t_reset_pulse();
    t_in_pulse();
    t_drop();
    t_fields();
    t_no_strobe();
    t_bad_reset();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule